// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block owns the instruction address of a small 8-bit core with 18-bit instruction words. Each clock it chooses where the next fetch comes from. The choices are the following slot, a flag-qualified relative branch, an absolute jump, a subroutine call, or a subroutine return. The instruction decoder outside the block supplies one strobe per kind of transfer, the zero and carry flags, an 8-bit signed displacement and a 12-bit absolute target.

Calls save their return address in an internal last-in first-out store of eight entries, so subroutines can nest eight levels deep. A deeper call discards the oldest saved address. A return with nothing saved resumes at address 0. Each of these two events raises a one-cycle flag. A single hold input freezes the block during pipeline stalls.

Top module: `prog_seq`

## Requirements
- R1: A synchronous reset sets `pc_o` to 0, clears both event flags and discards every saved return address, so a return right after reset goes to 0.
- R2: With only `step_en` asserted, `pc_o` increases by one on the next clock, wrapping from 4095 to 0.
- R3: `br_cond` selects the branch test: 00 means zero flag set, 01 means zero flag clear, 10 means carry flag set and 11 means carry flag clear. A branch whose test fails advances `pc_o` by one.
- R4: A taken branch loads `pc_o + 1 + sign_extend(br_disp)`, with `br_disp` read as two's complement and the sum taken modulo 4096, so the branch can move forward or backward.
- R5: `jmp_en` loads `jmp_target` into `pc_o` on the next clock.
- R6: `call_en` saves `pc_o + 1` (modulo 4096) and loads `jmp_target`.
- R7: `ret_en` loads the most recently saved address and removes it, so calls nested up to eight deep return in reverse order.
- R8: A call made while eight addresses are already saved discards the oldest one. `stk_ovf_o` is high for exactly the cycle that follows that call.
- R9: A return with no saved address loads 0. `stk_unf_o` is high for exactly the cycle that follows that return.
- R10: While `hold` is high, `pc_o` and the saved addresses stay unchanged, whatever strobes are present, and both event flags stay low.
- R11: When several strobes are high together, the order of precedence is return, then call, then jump, then branch, then step. With no strobe high, `pc_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Stall: freezes all state |
| step_en | input | 1 | Advance to next slot |
| br_en | input | 1 | Conditional relative branch |
| br_cond | input | 2 | Branch test select |
| jmp_en | input | 1 | Absolute jump |
| call_en | input | 1 | Subroutine call |
| ret_en | input | 1 | Subroutine return |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| br_disp | input | 8 | Signed branch displacement |
| jmp_target | input | 12 | Jump or call target address |
| pc_o | output | 12 | Current instruction address |
| stk_ovf_o | output | 1 | One-cycle pulse: oldest return address discarded |
| stk_unf_o | output | 1 | One-cycle pulse: return with nothing saved |

## Verification
Every result of this block is due exactly one clock after the strobes that cause it: the new `pc_o` and both event flags come from registers loaded on the same edge. The bench therefore drives the inputs on a falling edge and updates its own reference model at that moment. It then waits for the next falling edge and compares the address and both flags, so each comparison sits half a period after the edge that produced it. No event has a result that appears later or lingers longer, so an extra or missing pipeline stage shows up as a mismatch.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        SEL_IDLE = 3'd0,
        SEL_STEP = 3'd1,
        SEL_BR   = 3'd2,
        SEL_JMP  = 3'd3,
        SEL_CALL = 3'd4,
        SEL_RET  = 3'd5,
        SEL_HOLD = 3'd6
    } nxt_sel_e;

    typedef enum logic [1:0] {
        COND_ZS = 2'b00,
        COND_ZC = 2'b01,
        COND_CS = 2'b10,
        COND_CC = 2'b11
    } br_cond_e;

    function automatic logic cond_met(input logic [1:0] code,
                                      input logic       z,
                                      input logic       c);
        logic r;
        case (br_cond_e'(code))
            COND_ZS: r = z;
            COND_ZC: r = ~z;
            COND_CS: r = c;
            default: r = ~c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pseq_select.sv
module pseq_select
    import pseq_pkg::*;
(
    input  logic       hold,
    input  logic       step_en,
    input  logic       br_en,
    input  logic [1:0] br_cond,
    input  logic       jmp_en,
    input  logic       call_en,
    input  logic       ret_en,
    input  logic       flag_z,
    input  logic       flag_c,
    output nxt_sel_e   sel_o,
    output logic       taken_o
);

    always_comb begin
        taken_o = 1'b0;
        if (hold)         sel_o = SEL_HOLD;
        else if (ret_en)  sel_o = SEL_RET;
        else if (call_en) sel_o = SEL_CALL;
        else if (jmp_en)  sel_o = SEL_JMP;
        else if (br_en) begin
            sel_o   = SEL_BR;
            taken_o = cond_met(br_cond, flag_z, flag_c);
        end
        else if (step_en) sel_o = SEL_STEP;
        else              sel_o = SEL_IDLE;
    end

endmodule

// File: rtl/pseq_addr.sv
module pseq_addr
    import pseq_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DISP_W = 8
) (
    input  nxt_sel_e           sel,
    input  logic               taken,
    input  logic [PC_W-1:0]    pc,
    input  logic [DISP_W-1:0]  disp,
    input  logic [PC_W-1:0]    target,
    input  logic [PC_W-1:0]    pop_val,
    output logic [PC_W-1:0]    seq_addr_o,
    output logic [PC_W-1:0]    pc_d
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] br_addr;

    always_comb begin
        seq_addr_o = pc + 1'b1;
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        br_addr    = seq_addr_o + disp_ext;
        case (sel)
            SEL_STEP: pc_d = seq_addr_o;
            SEL_BR:   pc_d = taken ? br_addr : seq_addr_o;
            SEL_JMP:  pc_d = target;
            SEL_CALL: pc_d = target;
            SEL_RET:  pc_d = pop_val;
            default:  pc_d = pc;
        endcase
    end

endmodule

// File: rtl/pseq_retstack.sv
module pseq_retstack #(
    parameter int AW    = 12,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] pop_val,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] sp;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] sp_dec;

    always_comb begin
        sp_dec  = st_q.sp - 1'b1;
        empty_o = (st_q.cnt == '0);
        pop_val = empty_o ? '0 : mem_q[sp_dec];
        ovf_o   = st_q.ovf;
        unf_o   = st_q.unf;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (push) begin
            st_d.sp = st_q.sp + 1'b1;
            if (st_q.cnt == FULL_CNT) st_d.ovf = 1'b1;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop) begin
            if (empty_o) begin
                st_d.unf = 1'b1;
            end else begin
                st_d.sp  = sp_dec;
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.sp] <= push_val;
    end

    AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (rst) st_q.cnt <= FULL_CNT); // R7
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst) push |=> !empty_o); // R6
    AST_OVF_FULL:   assert property (@(posedge clk) disable iff (rst) ovf_o |-> st_q.cnt == FULL_CNT); // R8
    AST_UNF_EMPTY:  assert property (@(posedge clk) disable iff (rst) unf_o |-> empty_o); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({ovf_o, unf_o})); // R8

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import pseq_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DISP_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              step_en,
    input  logic              br_en,
    input  logic [1:0]        br_cond,
    input  logic              jmp_en,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [PC_W-1:0]   jmp_target,
    output logic [PC_W-1:0]   pc_o,
    output logic              stk_ovf_o,
    output logic              stk_unf_o
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    nxt_sel_e      sel;
    logic          taken;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] pop_val;
    logic          stk_empty;
    logic          push, pop;

    pseq_select u_select (
        .hold    (hold),
        .step_en (step_en),
        .br_en   (br_en),
        .br_cond (br_cond),
        .jmp_en  (jmp_en),
        .call_en (call_en),
        .ret_en  (ret_en),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .sel_o   (sel),
        .taken_o (taken)
    );

    pseq_addr #(.PC_W(PC_W), .DISP_W(DISP_W)) u_addr (
        .sel        (sel),
        .taken      (taken),
        .pc         (st_q.pc),
        .disp       (br_disp),
        .target     (jmp_target),
        .pop_val    (pop_val),
        .seq_addr_o (seq_addr),
        .pc_d       (pc_next)
    );

    pseq_retstack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_val (seq_addr),
        .pop_val  (pop_val),
        .empty_o  (stk_empty),
        .ovf_o    (stk_ovf_o),
        .unf_o    (stk_unf_o)
    );

    always_comb begin
        push    = (sel == SEL_CALL);
        pop     = (sel == SEL_RET);
        st_d    = st_q;
        st_d.pc = pc_next;
        pc_o    = st_q.pc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst) hold |=> st_q.pc == $past(st_q.pc)); // R10
    AST_HOLD_QUIET:  assert property (@(posedge clk) disable iff (rst) hold |=> !stk_ovf_o && !stk_unf_o); // R10
    AST_STEP_INC:    assert property (@(posedge clk) disable iff (rst) (sel == SEL_STEP) |=> st_q.pc == PC_W'($past(st_q.pc) + 1'b1)); // R2
    AST_JUMP_LOAD:   assert property (@(posedge clk) disable iff (rst) (sel == SEL_JMP) |=> st_q.pc == $past(jmp_target)); // R5
    AST_RET_EMPTY:   assert property (@(posedge clk) disable iff (rst) (sel == SEL_RET && stk_empty) |=> st_q.pc == '0 && stk_unf_o); // R9
    AST_IDLE_KEEP:   assert property (@(posedge clk) disable iff (rst) (sel == SEL_IDLE) |=> $stable(st_q.pc)); // R11

endmodule

// File: tb/prog_seq_tb_top.sv
module prog_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst, hold, step_en, br_en, jmp_en, call_en, ret_en, flag_z, flag_c;
    logic [1:0]  br_cond;
    logic [7:0]  br_disp;
    logic [11:0] jmp_target;
    logic [11:0] pc_o;
    logic        stk_ovf_o, stk_unf_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [11:0] m_pc;
    logic [11:0] m_stk [8];
    int          m_cnt;
    logic        e_ovf, e_unf;
    string       m_tag;

    always #10 clk = ~clk;

    prog_seq dut_i (
        .clk(clk), .rst(rst), .hold(hold), .step_en(step_en), .br_en(br_en),
        .br_cond(br_cond), .jmp_en(jmp_en), .call_en(call_en), .ret_en(ret_en),
        .flag_z(flag_z), .flag_c(flag_c), .br_disp(br_disp), .jmp_target(jmp_target),
        .pc_o(pc_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    function automatic logic exp_taken(logic [1:0] c, logic z, logic cy);
        case (c)
            2'b00:   return z;
            2'b01:   return !z;
            2'b10:   return cy;
            default: return !cy;
        endcase
    endfunction

    task automatic model_step();
        logic [11:0] ra;
        e_ovf = 1'b0;
        e_unf = 1'b0;
        if (rst) begin
            m_pc = '0; m_cnt = 0; m_tag = "R1";
        end else if (hold) begin
            m_tag = "R10";
        end else if (ret_en) begin
            if (m_cnt == 0) begin
                m_pc = '0; e_unf = 1'b1; m_tag = "R9";
            end else begin
                m_cnt = m_cnt - 1; m_pc = m_stk[m_cnt]; m_tag = "R7";
            end
        end else if (call_en) begin
            ra = m_pc + 12'd1;
            if (m_cnt == 8) begin
                for (int i = 0; i < 7; i++) m_stk[i] = m_stk[i+1];
                m_stk[7] = ra; e_ovf = 1'b1; m_tag = "R8";
            end else begin
                m_stk[m_cnt] = ra; m_cnt = m_cnt + 1; m_tag = "R6";
            end
            m_pc = jmp_target;
        end else if (jmp_en) begin
            m_pc = jmp_target; m_tag = "R5";
        end else if (br_en) begin
            if (exp_taken(br_cond, flag_z, flag_c)) begin
                m_pc = m_pc + 12'd1 + {{4{br_disp[7]}}, br_disp}; m_tag = "R4";
            end else begin
                m_pc = m_pc + 12'd1; m_tag = "R3";
            end
        end else if (step_en) begin
            m_pc = m_pc + 12'd1; m_tag = "R2";
        end else begin
            m_tag = "R11";
        end
        if (!rst && !hold && $countones({step_en, br_en, jmp_en, call_en, ret_en}) > 1)
            m_tag = "R11";
    endtask

    task automatic clear_in();
        rst = 0; hold = 0; step_en = 0; br_en = 0; jmp_en = 0; call_en = 0; ret_en = 0;
        flag_z = 0; flag_c = 0; br_cond = 2'b00; br_disp = '0; jmp_target = '0;
    endtask

    // inputs are already set; the result is due one edge later
    task automatic tick();
        model_step();
        @(negedge clk);
        vectors++;
        if (pc_o !== m_pc) begin
            fails++;
            $display("FAIL %s pc_o actual %0d expected %0d", m_tag, pc_o, m_pc);
        end
        if (stk_ovf_o !== e_ovf) begin
            fails++;
            $display("FAIL %s stk_ovf_o actual %0b expected %0b", m_tag, stk_ovf_o, e_ovf);
        end
        if (stk_unf_o !== e_unf) begin
            fails++;
            $display("FAIL %s stk_unf_o actual %0b expected %0b", m_tag, stk_unf_o, e_unf);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        int unsigned r;
        seed = 32'd2024;
        r = $urandom(seed);
        m_pc = '0; m_cnt = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        clear_in();
        rst = 1;
        tick(); tick();                                // R1 reset state
        rst = 0;
        ret_en = 1; tick(); ret_en = 0;                // R1 and R9: empty after reset
        tick();                                        // R11 idle keeps pc
        jmp_en = 1; jmp_target = 12'd4095; tick(); jmp_en = 0;  // R5
        step_en = 1; tick(); step_en = 0;              // R2 wrap to 0
        jmp_en = 1; jmp_target = 12'd10; tick(); jmp_en = 0;
        br_en = 1; br_cond = 2'b00; flag_z = 1; br_disp = 8'hEC; tick();  // R4 backward wrap to 4087
        br_cond = 2'b01; tick();                       // R3 not taken
        br_cond = 2'b10; flag_c = 1; br_disp = 8'h7F; tick();  // R4 forward max
        br_cond = 2'b11; tick();                       // R3 not taken
        br_en = 0; flag_z = 0; flag_c = 0;
        // R8: nine nested calls, then R7 and R9: nine returns
        for (int i = 0; i < 9; i++) begin
            call_en = 1; jmp_target = 12'(100 * (i + 1)); tick();
        end
        call_en = 0;
        for (int i = 0; i < 9; i++) begin
            ret_en = 1; tick();
        end
        ret_en = 0;
        // R10: hold with every strobe active
        call_en = 1; jmp_target = 12'd300; tick(); call_en = 0;
        hold = 1; ret_en = 1; call_en = 1; jmp_en = 1; br_en = 1; step_en = 1;
        tick(); tick();
        hold = 0; call_en = 0; jmp_en = 0; br_en = 0; step_en = 0;
        tick();                                        // R7 return survives hold
        ret_en = 0;
        // R11 precedence
        call_en = 1; jmp_en = 1; step_en = 1; jmp_target = 12'd55; tick();
        ret_en = 1; tick();
        ret_en = 0; call_en = 0; br_en = 1; br_cond = 2'b00; flag_z = 1; br_disp = 8'h05; tick();
        clear_in();
        // constrained random
        for (int n = 0; n < 6000; n++) begin
            r = $urandom;
            rst        = (r % 400) == 0;
            hold       = ((r >> 9) % 10) == 0;
            r = $urandom;
            step_en    = r[0];
            br_en      = r[1] & r[2];
            jmp_en     = (r[5:3] == 3'd0);
            call_en    = (r[8:6] < 3'd2);
            ret_en     = (r[11:9] < 3'd2);
            br_cond    = r[13:12];
            flag_z     = r[14];
            flag_c     = r[15];
            br_disp    = r[23:16];
            jmp_target = 12'($urandom);
            tick();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule